// File: doc/BRIEF.md
# Jumbo-Prefix Immediate Assembling Predecoder

This block sits between instruction fetch and the main decoder. Each cycle it may receive a 96-bit fetch window holding six 16-bit halfwords in little-endian address order. It forms three 32-bit words from these halfwords. The halfword at the lower address becomes the upper half of each word. Words whose top byte is 0xFE or 0xFF are extension prefixes: each carries a 24-bit payload that widens the immediate of the instruction after it.

The block walks the chain of leading prefixes to find the instruction that ends it. For that instruction it reports:

- the word itself;
- the total encoded length (32, 64 or 96 bits);
- a per-slot map of which words became NOPs and which slot holds the real instruction;
- a 64-bit glued immediate;
- a tag that tells the operand stage how the immediate was joined.

A window made entirely of prefixes is flagged as an illegal sequence. In that case no instruction is produced.

All results are computed combinationally from the window and captured in one register stage. They are qualified by a valid flag that follows the input valid.

Top module: `pd_jumbo_predecode`

## Requirements
- R1: Halfword k of the window is in_window[16k+15:16k]. Slot i is the 32-bit word {halfword 2i, halfword 2i+1}. out_insn carries the full slot word of the instruction that ends the chain.
- R2: A slot is a prefix exactly when its bits [31:24] equal 0xFE or 0xFF. Every other top byte marks an ordinary instruction word.
- R3: When slot 0 is not a prefix, the result is as follows:
  - out_len = 1 (32-bit), out_sel = 3'b001, out_nop = 3'b000;
  - out_imm_src = 0 (local);
  - out_imm = slot 0 bits [15:0], zero-extended to 64 bits.
- R4: When only slot 0 is a prefix, the result is as follows:
  - out_len = 2 (64-bit), out_sel = 3'b010, out_nop = 3'b001;
  - out_imm_src = 1 (one prefix joined);
  - out_imm = {24 zero bits, slot 0 bits [23:0], slot 1 bits [15:0]}.
- R5: When slots 0 and 1 are prefixes and slot 2 is not, the result is as follows:
  - out_len = 3 (96-bit), out_sel = 3'b100, out_nop = 3'b011;
  - out_imm_src = 2 (two prefixes joined);
  - out_imm = {slot 0 bits [23:0], slot 1 bits [23:0], slot 2 bits [15:0]}, with earlier payloads more significant.
- R6: The halfword sequence FE01, 2345, FE67, 89AB, F804, CDEF decodes to out_len = 3, out_insn = 0xF804CDEF and out_imm = 0x0123456789ABCDEF.
- R7: When all three slots are prefixes, out_illegal = 1 and all other result fields are zero: out_len = 0, out_sel = 0, out_nop = 0, out_imm_src = 0, out_insn = 0, out_imm = 0. In every other case out_illegal = 0.
- R8: Results for a window accepted with in_valid high appear on the outputs after the next rising clock edge. out_valid is in_valid delayed by one cycle.
- R9: While in_valid is low, every result output holds its previous value. Only out_valid drops.
- R10: While rst is high, every output is zero.
- R11: Slots after the one holding the instruction have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window below is to be predecoded |
| in_window | input | 96 | Six little-endian halfwords, lowest address in bits [15:0] |
| out_valid | output | 1 | Results below belong to a window accepted one cycle ago |
| out_illegal | output | 1 | Window consisted only of prefixes |
| out_len | output | 2 | Encoded length: 0 none, 1 = 32, 2 = 64, 3 = 96 bits |
| out_imm_src | output | 2 | Immediate source tag: 0 local, 1 one prefix joined, 2 two joined |
| out_nop | output | 3 | Per slot, 1 where a prefix was consumed as a NOP |
| out_sel | output | 3 | One-hot slot holding the real instruction |
| out_insn | output | 32 | Assembled word of the instruction |
| out_imm | output | 64 | Glued immediate |

## Verification
Every result is due exactly one rising edge after the window is presented with in_valid high. The bench drives each window on a falling edge and compares all outputs on the following falling edge, half a period after the capturing edge.

Hold behaviour is checked by dropping in_valid and changing the window in the same falling-edge slot. One cycle later, out_valid must be low and every result field must still match the earlier window.

Reset values are sampled on a falling edge while rst is still high.

// File: rtl/pd_jumbo_pkg.sv
package pd_jumbo_pkg;

    parameter int HALF_W   = 16;
    parameter int NSLOT    = 3;
    parameter int SLOT_W   = 2 * HALF_W;
    parameter int WIN_W    = NSLOT * SLOT_W;
    parameter int TAG_W    = 8;
    parameter int PAY_W    = SLOT_W - TAG_W;
    parameter int LOCIMM_W = 16;
    parameter int IMM_W    = 64;
    parameter int LEN_W    = 2;
    parameter int SRC_W    = 2;

    parameter logic [TAG_W-1:0] PFX_TAG_LO = 8'hFE;
    parameter logic [TAG_W-1:0] PFX_TAG_HI = 8'hFF;

    typedef enum logic [LEN_W-1:0] {
        LEN_NONE = 2'd0,
        LEN_32   = 2'd1,
        LEN_64   = 2'd2,
        LEN_96   = 2'd3
    } len_e;

    typedef enum logic [SRC_W-1:0] {
        IMM_SRC_LOCAL = 2'd0,
        IMM_SRC_JOIN1 = 2'd1,
        IMM_SRC_JOIN2 = 2'd2,
        IMM_SRC_RSVD  = 2'd3
    } imm_src_e;

    typedef struct packed {
        logic [SLOT_W-1:0] word;
        logic              is_pfx;
    } slot_t;

    typedef struct packed {
        logic              illegal;
        len_e              len;
        imm_src_e          src;
        logic [NSLOT-1:0]  nop;
        logic [NSLOT-1:0]  sel;
        logic [SLOT_W-1:0] insn;
        logic [IMM_W-1:0]  imm;
    } result_t;

    function automatic logic tag_is_prefix(input logic [TAG_W-1:0] tag);
        return (tag == PFX_TAG_LO) || (tag == PFX_TAG_HI);
    endfunction

    function automatic logic [SLOT_W-1:0] join_halves(input logic [HALF_W-1:0] hi_addr_lo,
                                                      input logic [HALF_W-1:0] hi_addr_hi);
        return {hi_addr_lo, hi_addr_hi};
    endfunction

endpackage

// File: rtl/pd_slot_former.sv
module pd_slot_former
    import pd_jumbo_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [WIN_W-1:0] window_i,
    input  logic             chain_i,
    output slot_t            slot_o,
    output logic             chain_o,
    output logic             nop_o,
    output logic             insn_o
);
    localparam int HW_FIRST  = 2 * IDX;
    localparam int HW_SECOND = 2 * IDX + 1;

    logic [HALF_W-1:0] hw_first;
    logic [HALF_W-1:0] hw_second;

    always_comb begin
        hw_first       = window_i[HW_FIRST*HALF_W +: HALF_W];
        hw_second      = window_i[HW_SECOND*HALF_W +: HALF_W];
        slot_o.word    = join_halves(hw_first, hw_second);
        slot_o.is_pfx  = tag_is_prefix(slot_o.word[SLOT_W-1 -: TAG_W]);
        // chain_i: every earlier slot was a prefix
        chain_o        = chain_i & slot_o.is_pfx;
        nop_o          = chain_i & slot_o.is_pfx;
        insn_o         = chain_i & ~slot_o.is_pfx;
    end
endmodule

// File: rtl/pd_chain_resolve.sv
module pd_chain_resolve
    import pd_jumbo_pkg::*;
(
    input  logic [NSLOT*SLOT_W-1:0] words_i,
    input  logic [NSLOT-1:0]        nop_i,
    input  logic [NSLOT-1:0]        sel_i,
    input  logic                    overrun_i,
    output result_t                 res_o
);
    logic [IMM_W-1:0] cand [NSLOT];

    genvar gk;
    generate
        for (gk = 0; gk < NSLOT; gk++) begin : g_cand
            always_comb begin
                cand[gk] = '0;
                cand[gk][LOCIMM_W-1:0] = words_i[gk*SLOT_W +: LOCIMM_W];
                for (int j = 0; j < gk; j++) begin
                    cand[gk][LOCIMM_W + (gk-1-j)*PAY_W +: PAY_W] = words_i[j*SLOT_W +: PAY_W];
                end
            end
        end
    endgenerate

    always_comb begin
        res_o         = '0;
        res_o.illegal = overrun_i;
        if (!overrun_i) begin
            res_o.nop = nop_i;
            res_o.sel = sel_i;
            for (int k = 0; k < NSLOT; k++) begin
                if (sel_i[k]) begin
                    res_o.len  = len_e'(LEN_W'(k + 1));
                    res_o.src  = imm_src_e'(SRC_W'(k));
                    res_o.insn = words_i[k*SLOT_W +: SLOT_W];
                    res_o.imm  = cand[k];
                end
            end
        end
    end
endmodule

// File: rtl/pd_result_reg.sv
module pd_result_reg
    import pd_jumbo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid_i,
    input  result_t res_i,
    output logic    valid_o,
    output result_t res_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                res_o <= res_i;
            end
        end
    end

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    // R8
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(res_o));

    // R7
    illegal_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && res_o.illegal) |-> (res_o.sel == '0 && res_o.len == LEN_NONE && res_o.nop == '0));

    // R3
    single_insn_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !res_o.illegal) |-> ($countones(res_o.sel) == 1));

    // R5
    nop_below_insn_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !res_o.illegal) |-> (res_o.nop == NSLOT'(res_o.sel - 1'b1)));
endmodule

// File: rtl/pd_jumbo_predecode.sv
module pd_jumbo_predecode
    import pd_jumbo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [95:0]       in_window,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [1:0]        out_len,
    output logic [1:0]        out_imm_src,
    output logic [2:0]        out_nop,
    output logic [2:0]        out_sel,
    output logic [31:0]       out_insn,
    output logic [63:0]       out_imm
);
    slot_t                   slots [NSLOT];
    logic [NSLOT:0]          chain;
    logic [NSLOT-1:0]        nop_raw;
    logic [NSLOT-1:0]        sel_raw;
    logic [NSLOT*SLOT_W-1:0] words_flat;
    result_t                 res_comb;
    result_t                 res_q;

    assign chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_slot
            pd_slot_former #(.IDX(gi)) u_slot (
                .window_i (in_window),
                .chain_i  (chain[gi]),
                .slot_o   (slots[gi]),
                .chain_o  (chain[gi+1]),
                .nop_o    (nop_raw[gi]),
                .insn_o   (sel_raw[gi])
            );
            assign words_flat[gi*SLOT_W +: SLOT_W] = slots[gi].word;
        end
    endgenerate

    pd_chain_resolve u_resolve (
        .words_i   (words_flat),
        .nop_i     (nop_raw),
        .sel_i     (sel_raw),
        .overrun_i (chain[NSLOT]),
        .res_o     (res_comb)
    );

    pd_result_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .res_i   (res_comb),
        .valid_o (out_valid),
        .res_o   (res_q)
    );

    always_comb begin
        out_illegal = res_q.illegal;
        out_len     = res_q.len;
        out_imm_src = res_q.src;
        out_nop     = res_q.nop;
        out_sel     = res_q.sel;
        out_insn    = res_q.insn;
        out_imm     = res_q.imm;
    end

    // R4
    len64_map_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == 2'd2) |-> (out_sel == 3'b010 && out_imm_src == 2'd1));

    // R5
    len96_map_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == 2'd3) |-> (out_sel == 3'b100 && out_imm_src == 2'd2));
endmodule

// File: tb/tb_pd_jumbo_predecode.sv
`timescale 1ns/1ps
module tb_pd_jumbo_predecode;

    typedef struct packed {
        logic        valid;
        logic        illegal;
        logic [1:0]  len;
        logic [1:0]  src;
        logic [2:0]  nop;
        logic [2:0]  sel;
        logic [31:0] insn;
        logic [63:0] imm;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [95:0] in_window;
    logic        out_valid, out_illegal;
    logic [1:0]  out_len, out_imm_src;
    logic [2:0]  out_nop, out_sel;
    logic [31:0] out_insn;
    logic [63:0] out_imm;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    pd_jumbo_predecode dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_window(in_window),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_len(out_len),
        .out_imm_src(out_imm_src), .out_nop(out_nop), .out_sel(out_sel),
        .out_insn(out_insn), .out_imm(out_imm)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected below 50000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [95:0] mkwin(input logic [15:0] h0, h1, h2, h3, h4, h5);
        return {h5, h4, h3, h2, h1, h0};
    endfunction

    // Expected result from R1..R7
    function automatic obs_t model(input logic [95:0] w);
        obs_t e;
        logic [31:0] s [3];
        logic        p [3];
        e = '0;
        e.valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            s[i] = {w[32*i +: 16], w[32*i+16 +: 16]};
            p[i] = (s[i][31:24] == 8'hFE) || (s[i][31:24] == 8'hFF);
        end
        if (!p[0]) begin
            e.len = 2'd1; e.sel = 3'b001; e.insn = s[0];
            e.imm = {48'h0, s[0][15:0]};
        end else if (!p[1]) begin
            e.len = 2'd2; e.sel = 3'b010; e.nop = 3'b001; e.src = 2'd1; e.insn = s[1];
            e.imm = {24'h0, s[0][23:0], s[1][15:0]};
        end else if (!p[2]) begin
            e.len = 2'd3; e.sel = 3'b100; e.nop = 3'b011; e.src = 2'd2; e.insn = s[2];
            e.imm = {s[0][23:0], s[1][23:0], s[2][15:0]};
        end else begin
            e.illegal = 1'b1;
        end
        return e;
    endfunction

    function automatic obs_t grab();
        return {out_valid, out_illegal, out_len, out_imm_src, out_nop, out_sel, out_insn, out_imm};
    endfunction

    task automatic check(input string req, input obs_t exp);
        obs_t got;
        got = grab();
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input string req, input logic [95:0] w);
        in_valid  = 1'b1;
        in_window = w;
        @(negedge clk);
        check(req, model(w));
    endtask

    function automatic logic [31:0] rand_slot();
        logic [31:0] v;
        v = $urandom;
        if ($urandom % 3 == 0) v[31:24] = 8'hFE | 8'($urandom % 2);
        else                   v[31:24] = 8'($urandom % 254);
        return v;
    endfunction

    initial begin
        obs_t held;
        logic [95:0] w;
        void'($urandom(32'd20240607));
        rst = 1'b1; in_valid = 1'b0; in_window = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", '0);
        in_valid = 1'b1; in_window = mkwin(16'hFE01, 16'h2345, 16'hFE67, 16'h89AB, 16'hF804, 16'hCDEF);
        @(negedge clk);
        check("R10", '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        // R6 reference chain, with explicit constants
        drive("R6", mkwin(16'hFE01, 16'h2345, 16'hFE67, 16'h89AB, 16'hF804, 16'hCDEF));
        n_tests++;
        if (out_imm !== 64'h0123456789ABCDEF || out_insn !== 32'hF804CDEF || out_len !== 2'd3) begin
            n_fail++;
            $display("FAIL R6: actual imm %h insn %h len %0d expected 0123456789abcdef f804cdef 3",
                     out_imm, out_insn, out_len);
        end

        // R1 R3 plain 32-bit word; halfword order
        drive("R1", mkwin(16'h1234, 16'h5678, 16'h0000, 16'h0000, 16'h0000, 16'h0000));
        n_tests++;
        if (out_insn !== 32'h12345678) begin
            n_fail++;
            $display("FAIL R1: actual %h expected 12345678", out_insn);
        end
        // R2 tag 0xFD is not a prefix, 0xFF is
        drive("R2", mkwin(16'hFD00, 16'h0001, 16'hFE00, 16'h0000, 16'h0000, 16'h0000));
        drive("R2", mkwin(16'hFFAA, 16'hBBCC, 16'h0300, 16'hDDEE, 16'h0000, 16'h0000));
        // R4 single prefix
        drive("R4", mkwin(16'hFEAB, 16'hCDEF, 16'h4000, 16'h1234, 16'hFFFF, 16'hFFFF));
        // R5 two prefixes
        drive("R5", mkwin(16'hFFFF, 16'hFFFF, 16'hFE00, 16'h0000, 16'h7777, 16'h8888));
        // R7 illegal all-prefix windows
        drive("R7", mkwin(16'hFE11, 16'h2233, 16'hFF44, 16'h5566, 16'hFE77, 16'h8899));
        drive("R7", mkwin(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF));
        // R11 trailing slots vary, result unchanged
        drive("R11", mkwin(16'h0102, 16'h0304, 16'hFEFE, 16'hFEFE, 16'hFFFF, 16'h0000));
        drive("R11", mkwin(16'h0102, 16'h0304, 16'h1111, 16'h2222, 16'h3333, 16'h4444));
        drive("R11", mkwin(16'hFE99, 16'h8877, 16'h0102, 16'h0304, 16'hFE00, 16'h0000));

        // R9 hold with in_valid low and a different window
        w = mkwin(16'hFE01, 16'h0203, 16'h0A0B, 16'h0C0D, 16'h0000, 16'h0000);
        drive("R8", w);
        held = model(w);
        in_valid = 1'b0;
        in_window = mkwin(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        @(negedge clk);
        held.valid = 1'b0;
        check("R9", held);
        @(negedge clk);
        check("R9", held);

        // Random windows, back to back and with gaps
        for (int n = 0; n < 600; n++) begin
            w = {rand_slot(), rand_slot(), rand_slot()};
            w = {w[79:64], w[95:80], w[47:32], w[63:48], w[15:0], w[31:16]};
            drive("R1 R3 R4 R5 R7 random", w);
            if (n % 7 == 0) begin
                held = model(w);
                held.valid = 1'b0;
                in_valid = 1'b0;
                in_window = $urandom;
                @(negedge clk);
                check("R9 random", held);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule